// File: doc/BRIEF.md
# Battery Query Command Responder

This block sits on the byte link between a host and a power/input controller and answers a battery query. Each transfer delivers one received byte with a one-cycle strobe. The block registers exactly one response byte per transfer, and the host shifts that byte out on the following transfer. When the block is idle it treats each received byte as a command. Only the battery-query code is acted on. Any other command gets the idle filler response and leaves the block where it was.

When the query code arrives, the block captures the two battery level inputs at that strobe and enters a streaming state. The host then clocks out the reply with dummy bytes. Either of two accepted dummy codes fetches the next byte of a three-byte reply. The first byte is the low eight bits of the main level. The second byte is the low eight bits of the backup level. The third byte carries the two upper bits of each level. When the third byte has been delivered, the block returns to idle. A byte in the streaming state that is not a dummy code produces a zero error byte and does not move the stream position.

Top module: `batq_responder`

## Requirements
- R1: While reset is asserted and after it is released, `tx_byte` reads 0x00 until the first strobe.
- R2: Receiving the query code (default 0xC0) while idle responds with the idle filler (default 0x11) and starts a reply at position 0.
- R3: The first dummy after a query returns bits 7:0 of the main level captured at the query strobe.
- R4: The second dummy returns bits 7:0 of the backup level captured at the query strobe.
- R5: The third dummy returns {4'b0000, backup[9:8], main[9:8]}, with the backup bits in 3:2 and the main bits in 1:0.
- R6: Both dummy codes (defaults 0x11 and 0x88) advance the reply identically, in any mix.
- R7: After the third reply byte the block is idle again, so a following dummy byte returns the idle filler.
- R8: A non-dummy byte during a reply, including the query code, returns 0x00 and keeps the reply position, so the next dummy returns the byte that was due.
- R9: Any byte other than the query code received while idle returns the idle filler and leaves the block idle.
- R10: `tx_byte` changes only on a clock edge where `rx_valid` is high.
- R11: Changes to the level inputs after the query strobe do not alter the reply bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| main_lvl | input | 10 | Main battery level |
| backup_lvl | input | 10 | Backup battery level |
| tx_byte | output | 8 | Response byte for the current transfer |

## Verification
The hardest situation to reach is a reply that is interrupted by stray bytes and then resumed. In that case the error byte must appear while the position is frozen, and the captured levels must survive input changes made during the interruption. The stimulus starts a query, draws one byte, and injects both a random byte and the query code itself. During the interruption it alters both level inputs, then resumes with the other dummy code. A long random run also mixes query codes, both dummy codes and arbitrary bytes with changing levels, and compares every cycle with a queue-based model.

// File: rtl/batq_pkg.sv
package batq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } batq_state_e;

  localparam int unsigned BATQ_REPLY_BYTES = 3;
endpackage

// File: rtl/batq_decode.sv
module batq_decode #(
  parameter logic [7:0] CMD_CODE = 8'hC0,
  parameter logic [7:0] DUMMY_A  = 8'h11,
  parameter logic [7:0] DUMMY_B  = 8'h88
) (
  input  logic [7:0] rx_byte,
  output logic       is_cmd,
  output logic       is_dummy
);
  always_comb begin
    is_cmd   = (rx_byte == CMD_CODE);
    is_dummy = (rx_byte == DUMMY_A) || (rx_byte == DUMMY_B);
  end
endmodule

// File: rtl/batq_fsm.sv
module batq_fsm
  import batq_pkg::*;
#(
  parameter int unsigned NBYTES = 3,
  localparam int unsigned IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             is_cmd,
  input  logic             is_dummy,
  output batq_state_e      state_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             load,
  output logic             emit_data,
  output logic             emit_err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

  batq_state_e      state_d;
  logic [IDX_W-1:0] idx_d;
  logic             upd_en;

  always_comb begin
    load      = strobe && (state_q == ST_IDLE) && is_cmd;
    emit_data = strobe && (state_q == ST_SEND) && is_dummy;
    emit_err  = strobe && (state_q == ST_SEND) && !is_dummy;
    upd_en    = load || emit_data;
    state_d   = state_q;
    idx_d     = idx_q;
    if (load) begin
      state_d = ST_SEND;
      idx_d   = '0;
    end else if (emit_data) begin
      if (idx_q == LAST_IDX) begin
        state_d = ST_IDLE;
        idx_d   = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/batq_snapshot.sv
module batq_snapshot #(
  parameter int unsigned LVL_W  = 10,
  parameter int unsigned NBYTES = 3,
  localparam int unsigned IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LVL_W-1:0] main_lvl,
  input  logic [LVL_W-1:0] backup_lvl,
  input  logic [IDX_W-1:0] sel,
  output logic [7:0]       data_byte
);
  localparam int unsigned HI_W = LVL_W - 8;

  logic [7:0] cap_d [NBYTES];
  logic [7:0] buf_q [NBYTES];

  always_comb begin
    for (int i = 0; i < NBYTES; i++) cap_d[i] = 8'h00;
    cap_d[0] = main_lvl[7:0];
    cap_d[1] = backup_lvl[7:0];
    cap_d[2] = 8'({backup_lvl[LVL_W-1 -: HI_W], main_lvl[LVL_W-1 -: HI_W]});
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_q[g] <= 8'h00;
      end else if (load) begin
        buf_q[g] <= cap_d[g];
      end
    end
  end

  always_comb begin
    data_byte = 8'h00;
    for (int i = 0; i < NBYTES; i++) begin
      if (sel == IDX_W'(i)) data_byte = buf_q[i];
    end
  end
endmodule

// File: rtl/batq_responder.sv
module batq_responder
  import batq_pkg::*;
#(
  parameter int unsigned LVL_W    = 10,
  parameter logic [7:0]  CMD_CODE = 8'hC0,
  parameter logic [7:0]  DUMMY_A  = 8'h11,
  parameter logic [7:0]  DUMMY_B  = 8'h88,
  parameter logic [7:0]  IDLE_RSP = 8'h11,
  parameter logic [7:0]  ERR_RSP  = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic [LVL_W-1:0] main_lvl,
  input  logic [LVL_W-1:0] backup_lvl,
  output logic [7:0]       tx_byte
);
  localparam int unsigned NBYTES = BATQ_REPLY_BYTES;
  localparam int unsigned IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic             is_cmd;
  logic             is_dummy;
  batq_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic             load;
  logic             emit_data;
  logic             emit_err;
  logic [7:0]       data_byte;
  logic [7:0]       tx_d;

  batq_decode #(
    .CMD_CODE (CMD_CODE),
    .DUMMY_A  (DUMMY_A),
    .DUMMY_B  (DUMMY_B)
  ) decode_i (
    .rx_byte  (rx_byte),
    .is_cmd   (is_cmd),
    .is_dummy (is_dummy)
  );

  batq_fsm #(
    .NBYTES (NBYTES)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (rx_valid),
    .is_cmd    (is_cmd),
    .is_dummy  (is_dummy),
    .state_q   (state_q),
    .idx_q     (idx_q),
    .load      (load),
    .emit_data (emit_data),
    .emit_err  (emit_err)
  );

  batq_snapshot #(
    .LVL_W  (LVL_W),
    .NBYTES (NBYTES)
  ) snap_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .main_lvl   (main_lvl),
    .backup_lvl (backup_lvl),
    .sel        (idx_q),
    .data_byte  (data_byte)
  );

  always_comb begin
    if (emit_data)     tx_d = data_byte;
    else if (emit_err) tx_d = ERR_RSP;
    else               tx_d = IDLE_RSP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte <= 8'h00;
    end else if (rx_valid) begin
      tx_byte <= tx_d;
    end
  end
endmodule

// File: rtl/batq_responder_chk.sv
module batq_responder_chk
  import batq_pkg::*;
#(
  parameter logic [7:0] CMD_CODE = 8'hC0,
  parameter logic [7:0] DUMMY_A  = 8'h11,
  parameter logic [7:0] DUMMY_B  = 8'h88,
  parameter logic [7:0] IDLE_RSP = 8'h11,
  parameter int unsigned IDX_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic [7:0]       rx_byte,
  input logic [7:0]       tx_byte,
  input batq_state_e      state_q,
  input logic [IDX_W-1:0] idx_q
);
  logic dum;
  assign dum = (rx_byte == DUMMY_A) || (rx_byte == DUMMY_B);

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(tx_byte)); // R10

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDX_W'(BATQ_REPLY_BYTES)); // R6

  AST_IDLE_NOT_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (idx_q == '0)); // R7

  AST_CMD_START: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && (state_q == ST_IDLE) && (rx_byte == CMD_CODE)
    |=> (state_q == ST_SEND) && (idx_q == '0) && (tx_byte == IDLE_RSP)); // R2

  AST_OTHER_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && (state_q == ST_IDLE) && (rx_byte != CMD_CODE)
    |=> (state_q == ST_IDLE) && (tx_byte == IDLE_RSP)); // R9

  AST_ERR_KEEPS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && (state_q == ST_SEND) && !dum
    |=> (tx_byte == 8'h00) && $stable(idx_q) && (state_q == ST_SEND)); // R8

  AST_WRAP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && (state_q == ST_SEND) && dum && (idx_q == IDX_W'(BATQ_REPLY_BYTES - 1))
    |=> (state_q == ST_IDLE)); // R7
endmodule

bind batq_responder batq_responder_chk #(
  .CMD_CODE (CMD_CODE),
  .DUMMY_A  (DUMMY_A),
  .DUMMY_B  (DUMMY_B),
  .IDLE_RSP (IDLE_RSP),
  .IDX_W    (IDX_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_valid (rx_valid),
  .rx_byte  (rx_byte),
  .tx_byte  (tx_byte),
  .state_q  (state_q),
  .idx_q    (idx_q)
);

// File: tb/batq_responder_tb_top.sv
`timescale 1ns/1ps
module batq_responder_tb_top;
  logic       clk;
  logic       rst_n;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic [9:0] main_lvl;
  logic [9:0] backup_lvl;
  logic [7:0] tx_byte;

  int unsigned n_tests;
  int unsigned n_fail;
  string       cur_req;

  // reference model state
  bit          ref_send;
  logic [7:0]  ref_q[$];
  logic [7:0]  ref_tx;

  batq_responder dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .main_lvl   (main_lvl),
    .backup_lvl (backup_lvl),
    .tx_byte    (tx_byte)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit is_dum(logic [7:0] b);
    return (b == 8'h11) || (b == 8'h88);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_send = 1'b0;
      ref_q.delete();
      ref_tx = 8'h00;
    end else if (rx_valid) begin
      if (!ref_send) begin
        ref_tx = 8'h11;
        if (rx_byte == 8'hC0) begin
          ref_send = 1'b1;
          ref_q.delete();
          ref_q.push_back(main_lvl[7:0]);
          ref_q.push_back(backup_lvl[7:0]);
          ref_q.push_back({4'b0000, backup_lvl[9:8], main_lvl[9:8]});
        end
      end else if (is_dum(rx_byte)) begin
        ref_tx = ref_q.pop_front();
        if (ref_q.size() == 0) ref_send = 1'b0;
      end else begin
        ref_tx = 8'h00;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_tests++;
      if (tx_byte !== ref_tx) begin
        n_fail++;
        $display("FAIL %s model: tx_byte=%02h expected %02h at %0t", cur_req, tx_byte, ref_tx, $time);
      end
    end
  end

  task automatic check(input logic [7:0] exp, input string req);
    n_tests++;
    if (tx_byte !== exp) begin
      n_fail++;
      $display("FAIL %s: tx_byte=%02h expected %02h", req, tx_byte, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_byte  = 8'h5A;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, tests=%0d expected completion", n_tests);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0; cur_req = "R1";
    rst_n = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00;
    main_lvl = '0; backup_lvl = '0;
    #1 check(8'h00, "R1");
    repeat (3) @(negedge clk);
    check(8'h00, "R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(8'h00, "R1");

    // R9: unknown command in idle, then dummy still idle
    cur_req = "R9";
    xfer(8'h55); check(8'h11, "R9");
    xfer(8'h11); check(8'h11, "R9");

    // R2..R7, R11
    cur_req = "R2";
    main_lvl = 10'h2A5; backup_lvl = 10'h1C3;
    xfer(8'hC0); check(8'h11, "R2");
    main_lvl = 10'h000; backup_lvl = 10'h3FF;
    cur_req = "R3";
    xfer(8'h11); check(8'hA5, "R3 R11");
    cur_req = "R4";
    xfer(8'h88); check(8'hC3, "R4 R6");
    cur_req = "R5";
    xfer(8'h11); check(8'h06, "R5");
    cur_req = "R7";
    xfer(8'h88); check(8'h11, "R7");

    // R8: interruption keeps position
    cur_req = "R8";
    main_lvl = 10'h3FF; backup_lvl = 10'h3FF;
    xfer(8'hC0); check(8'h11, "R2");
    xfer(8'h88); check(8'hFF, "R3");
    main_lvl = 10'h000; backup_lvl = 10'h000;
    xfer(8'h42); check(8'h00, "R8");
    xfer(8'hC0); check(8'h00, "R8");
    xfer(8'h11); check(8'hFF, "R8 R4 R11");
    xfer(8'h88); check(8'h0F, "R5");
    xfer(8'h11); check(8'h11, "R7");

    // R10: no strobe, tx holds while rx_byte wanders
    cur_req = "R10";
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); rx_byte = (i % 2) ? 8'hC0 : 8'h88;
      check(8'h11, "R10");
    end

    // R5 zero levels
    cur_req = "R5";
    xfer(8'hC0); xfer(8'h11); check(8'h00, "R3");
    xfer(8'h11); check(8'h00, "R4");
    xfer(8'h11); check(8'h00, "R5");

    // random mix, compared by the model every clock (R6 R8 R9 R11)
    cur_req = "R6";
    for (int i = 0; i < 2000; i++) begin
      int unsigned r;
      r = $urandom_range(0, 9);
      main_lvl   = 10'($urandom);
      backup_lvl = 10'($urandom);
      @(negedge clk);
      rx_valid = ($urandom_range(0, 3) != 0);
      case (r)
        0, 1:    rx_byte = 8'hC0;
        2, 3, 4: rx_byte = 8'h11;
        5, 6, 7: rx_byte = 8'h88;
        default: rx_byte = 8'($urandom);
      endcase
    end
    @(negedge clk); rx_valid = 1'b0;
    repeat (2) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule